// File: doc/BRIEF.md
# Pipeline Data-Hazard Interlock

This block is the read-after-write control for a four-stage in-order integer pipeline whose stages are fetch, decode (with register-file read), execute and write-back. Each cycle it compares the source register indices of the instruction sitting in decode with the destination indices of the two older instructions still in flight: the one in execute and the one in write-back. From the result it either holds fetch and decode while a no-op bubble goes into execute, or it steers a decode operand to the write-back stage result instead of the register file.

A producer writes the register file at the end of its write-back cycle, and the register file does not pass a value written in a cycle through to a read in the same cycle. A configuration input picks one of two policies. With the bypass off, a consumer directly behind its producer waits two cycles. With the bypass on, the consumer waits one cycle and then takes the write-back result. The stall, bubble and operand-select outputs are decided combinationally from the current stage contents in the same cycle. A small phase machine follows the interlock sequence. Its states are RUN (no interlock in progress), HOLD2 (a second stall is due, bypass off) and FWD (a forward is due, bypass on). From any state, a hit in execute moves it to HOLD2 when the bypass is off and to FWD when the bypass is on. In every other case it goes back to RUN. Reset puts it in RUN.

Top module: `hz_interlock`

## Requirements
- R1: When decode is valid and a used, non-zero source index equals the destination of a valid, writing instruction in execute, `stall` and `bubble` are both 1 in that same cycle, in either mode.
- R2: With `bypass_en` = 0, a used, non-zero source that matches a valid, writing instruction in write-back forces `stall` = 1. No same-cycle pass-through is assumed.
- R3: With `bypass_en` = 1 and no execute-stage match, a write-back match sets bit s of `src_from_wb` to 1 (1 = take the write-back result, 0 = register file) and does not stall.
- R4: When the same source matches both execute and write-back, the younger execute producer wins: the block stalls and bit s of `src_from_wb` stays 0. The other source may still forward.
- R5: Source index 0, a source whose `dec_src_use` bit is 0, and a producer that is invalid or does not write never cause a stall or a forward.
- R6: With `dec_valid` = 0, `stall`, `bubble` and `src_from_wb` are all 0.
- R7: A consumer directly behind its producer sees exactly two consecutive stall cycles with the bypass off. With the bypass on it sees one stall cycle followed by a forward from write-back.
- R8: During and right after reset, with no valid stage, every output is 0.
- R9: Random dependent programs run through a pipeline governed by the block yield the same per-instruction results and final registers as one-at-a-time execution. The execute-entry span matches the schedule implied by R7 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the phase machine |
| bypass_en | input | 1 | 1 = forward the write-back result into decode, 0 = interlock only |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_src_idx | input | NSRC*REG_AW | Source indices; source s in bits [s*REG_AW +: REG_AW] |
| dec_src_use | input | NSRC | Bit s = 1 when source s is read |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_dst | input | REG_AW | Execute destination index |
| wb_valid | input | 1 | Write-back stage holds a real instruction |
| wb_wen | input | 1 | Write-back instruction writes a register |
| wb_dst | input | REG_AW | Write-back destination index |
| stall | output | 1 | Hold the fetch and decode stage registers |
| bubble | output | 1 | Load a no-op into execute |
| src_from_wb | output | NSRC | Per-source operand select, 1 = write-back result |

## Verification
`stall`, `bubble` and `src_from_wb` depend only on the stage contents present in the same cycle. The bench therefore changes inputs two nanoseconds after a rising edge and reads the outputs in that same low-risk window, with no clock edge in between. The phase machine takes one edge to update, so the R7 sequences compare the second stall or the forward one cycle after the first stall. In the pipeline runs, an instruction's operands are read on the cycle its decode slot is released. Its result is compared two cycles later when it leaves write-back, and final registers are compared after the pipeline drains.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Interlock phase tracked between cycles
    typedef enum logic [1:0] {
        HZ_RUN   = 2'd0,
        HZ_HOLD2 = 2'd1,
        HZ_FWD   = 2'd2
    } hz_state_e;

    // Operand source choice for one decode operand
    typedef enum logic {
        OPS_RF = 1'b0,
        OPS_WB = 1'b1
    } opsel_e;

    // Match result of one decode source against the older stages
    typedef struct packed {
        logic x_hit;
        logic w_hit;
    } src_hit_t;

endpackage

// File: rtl/hz_src_cmp.sv
module hz_src_cmp #(
    parameter int REG_AW = 5
) (
    input  logic              dec_valid,
    input  logic [REG_AW-1:0] src_idx,
    input  logic              src_use,
    input  logic              ex_valid,
    input  logic              ex_wen,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              wb_valid,
    input  logic              wb_wen,
    input  logic [REG_AW-1:0] wb_dst,
    output hz_pkg::src_hit_t  hit
);
    localparam logic [REG_AW-1:0] ZERO_IDX = '0;

    logic live;
    logic ex_writes;
    logic wb_writes;

    // A source can only depend on something if it is real and not the zero register
    assign live      = dec_valid && src_use && (src_idx != ZERO_IDX);
    assign ex_writes = ex_valid && ex_wen;
    assign wb_writes = wb_valid && wb_wen;

    always_comb begin
        hit.x_hit = live && ex_writes && (ex_dst == src_idx);
        hit.w_hit = live && wb_writes && (wb_dst == src_idx);
    end

endmodule

// File: rtl/hz_seq.sv
module hz_seq
    import hz_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bypass_en,
    input  logic [NSRC-1:0] x_hits,
    input  logic [NSRC-1:0] w_hits,
    output logic            stall,
    output logic            bubble,
    output logic [NSRC-1:0] src_from_wb,
    output hz_state_e       phase
);
    hz_state_e state_q;
    hz_state_e state_d;
    logic      any_x;
    logic      any_w;

    assign any_x = |x_hits;
    assign any_w = |w_hits;
    assign phase = state_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HZ_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next phase: an execute-stage hit decides what the following cycle owes
    always_comb begin
        state_d = HZ_RUN;
        unique case (state_q)
            HZ_RUN, HZ_HOLD2, HZ_FWD: begin
                if (any_x) begin
                    state_d = bypass_en ? HZ_FWD : HZ_HOLD2;
                end else begin
                    state_d = HZ_RUN;
                end
            end
            default: state_d = HZ_RUN;
        endcase
    end

    // Outputs: decided from the stage contents of this cycle
    always_comb begin
        stall  = any_x || (!bypass_en && any_w);
        bubble = stall;
        for (int s = 0; s < NSRC; s++) begin
            src_from_wb[s] = (bypass_en && w_hits[s] && !x_hits[s]) ? OPS_WB : OPS_RF;
        end
    end

    // A non-RUN phase means a bubble was just placed in execute
    AST_BUBBLE_LANDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != HZ_RUN) |-> !any_x); // R7

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int NSRC   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bypass_en,
    input  logic                   dec_valid,
    input  logic [NSRC*REG_AW-1:0] dec_src_idx,
    input  logic [NSRC-1:0]        dec_src_use,
    input  logic                   ex_valid,
    input  logic                   ex_wen,
    input  logic [REG_AW-1:0]      ex_dst,
    input  logic                   wb_valid,
    input  logic                   wb_wen,
    input  logic [REG_AW-1:0]      wb_dst,
    output logic                   stall,
    output logic                   bubble,
    output logic [NSRC-1:0]        src_from_wb
);
    localparam int IDX_W = NSRC * REG_AW;
    localparam logic [IDX_W-1:0] ALL_ZERO = '0;

    src_hit_t        hits [NSRC];
    logic [NSRC-1:0] x_hits;
    logic [NSRC-1:0] w_hits;
    hz_state_e       phase;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        hz_src_cmp #(.REG_AW(REG_AW)) u_cmp (
            .dec_valid (dec_valid),
            .src_idx   (dec_src_idx[s*REG_AW +: REG_AW]),
            .src_use   (dec_src_use[s]),
            .ex_valid  (ex_valid),
            .ex_wen    (ex_wen),
            .ex_dst    (ex_dst),
            .wb_valid  (wb_valid),
            .wb_wen    (wb_wen),
            .wb_dst    (wb_dst),
            .hit       (hits[s])
        );
        assign x_hits[s] = hits[s].x_hit;
        assign w_hits[s] = hits[s].w_hit;

        // Younger producer in execute overrides an older write-back match
        AST_YOUNGEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            x_hits[s] |-> (!src_from_wb[s] && stall)); // R4
    end

    hz_seq #(.NSRC(NSRC)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .bypass_en   (bypass_en),
        .x_hits      (x_hits),
        .w_hits      (w_hits),
        .stall       (stall),
        .bubble      (bubble),
        .src_from_wb (src_from_wb),
        .phase       (phase)
    );

    AST_EX_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|x_hits) |-> (stall && bubble)); // R1

    AST_NOFWD_WB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_en && (|w_hits)) |-> stall); // R2

    AST_BYP_TAKES_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_en && !(|x_hits)) |-> (!stall && (src_from_wb == w_hits))); // R3

    AST_ZERO_IDX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_src_idx == ALL_ZERO) |-> (!stall && (src_from_wb == '0))); // R5

    AST_IDLE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!stall && !bubble && (src_from_wb == '0))); // R6

    AST_SECOND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == HZ_HOLD2 && !bypass_en && dec_valid) |-> stall); // R7

    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == HZ_FWD && bypass_en) |-> !stall); // R7

endmodule

// File: tb/tb_hz_interlock.sv
`timescale 1ns/1ps
module tb_hz_interlock;
    localparam int AW = 5;
    localparam int NI = 40;
    localparam int WD = 20000;

    typedef struct packed {
        logic byp; logic dv;
        logic [4:0] r1; logic u1; logic [4:0] r2; logic u2;
        logic xv; logic xw; logic [4:0] xd;
        logic wv; logic ww; logic [4:0] wd;
        logic es; logic [1:0] ef;
    } vec_t;

    // byp dv  r1   u1  r2   u2  xv xw xd   wv ww wd  | stall fwd
    localparam vec_t VEC [13] = '{
        '{1'b0,1'b1,5'd3,1'b1,5'd4,1'b1,1'b1,1'b1,5'd3,1'b0,1'b0,5'd0,1'b1,2'b00}, // R1 no-fwd
        '{1'b1,1'b1,5'd3,1'b1,5'd4,1'b1,1'b1,1'b1,5'd4,1'b0,1'b0,5'd0,1'b1,2'b00}, // R1 bypass
        '{1'b0,1'b1,5'd5,1'b1,5'd6,1'b1,1'b0,1'b0,5'd0,1'b1,1'b1,5'd5,1'b1,2'b00}, // R2
        '{1'b1,1'b1,5'd5,1'b1,5'd6,1'b1,1'b0,1'b0,5'd0,1'b1,1'b1,5'd5,1'b0,2'b01}, // R3
        '{1'b1,1'b1,5'd7,1'b1,5'd7,1'b1,1'b0,1'b0,5'd0,1'b1,1'b1,5'd7,1'b0,2'b11}, // R3 both
        '{1'b1,1'b1,5'd9,1'b1,5'd2,1'b1,1'b1,1'b1,5'd9,1'b1,1'b1,5'd9,1'b1,2'b00}, // R4
        '{1'b1,1'b1,5'd9,1'b1,5'd2,1'b1,1'b1,1'b1,5'd9,1'b1,1'b1,5'd2,1'b1,2'b10}, // R4 split
        '{1'b0,1'b1,5'd0,1'b1,5'd0,1'b1,1'b1,1'b1,5'd0,1'b1,1'b1,5'd0,1'b0,2'b00}, // R5 zero
        '{1'b0,1'b1,5'd3,1'b0,5'd4,1'b0,1'b1,1'b1,5'd3,1'b1,1'b1,5'd4,1'b0,2'b00}, // R5 unused
        '{1'b0,1'b1,5'd3,1'b1,5'd4,1'b1,1'b1,1'b0,5'd3,1'b1,1'b0,5'd4,1'b0,2'b00}, // R5 no write
        '{1'b1,1'b1,5'd3,1'b1,5'd4,1'b1,1'b0,1'b1,5'd3,1'b0,1'b1,5'd4,1'b0,2'b00}, // R5 invalid
        '{1'b0,1'b0,5'd3,1'b1,5'd4,1'b1,1'b1,1'b1,5'd3,1'b1,1'b1,5'd4,1'b0,2'b00}, // R6
        '{1'b1,1'b0,5'd3,1'b1,5'd3,1'b1,1'b0,1'b0,5'd0,1'b1,1'b1,5'd3,1'b0,2'b00}  // R6 bypass
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bypass_en = 1'b0;
    logic dec_valid = 1'b0;
    logic [2*AW-1:0] dec_src_idx = '0;
    logic [1:0] dec_src_use = '0;
    logic ex_valid = 1'b0, ex_wen = 1'b0;
    logic [AW-1:0] ex_dst = '0;
    logic wb_valid = 1'b0, wb_wen = 1'b0;
    logic [AW-1:0] wb_dst = '0;
    logic stall, bubble;
    logic [1:0] src_from_wb;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;

    int p_op [NI], p_rd [NI], p_r1 [NI], p_r2 [NI];
    int t_s [NI], xc [NI];
    logic [31:0] ref_res [NI];
    logic [31:0] rf [8], ref_rf [8];

    always #4 clk = ~clk;

    hz_interlock #(.REG_AW(AW), .NSRC(2)) dut (
        .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en),
        .dec_valid(dec_valid), .dec_src_idx(dec_src_idx), .dec_src_use(dec_src_use),
        .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_dst(ex_dst),
        .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_dst(wb_dst),
        .stall(stall), .bubble(bubble), .src_from_wb(src_from_wb)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] alu(input int op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            0: alu = a + b;
            1: alu = a - b;
            2: alu = a ^ b;
            default: alu = a & b;
        endcase
    endfunction

    task automatic idle_inputs();
        dec_valid = 1'b0; dec_src_idx = '0; dec_src_use = '0;
        ex_valid = 1'b0; ex_wen = 1'b0; ex_dst = '0;
        wb_valid = 1'b0; wb_wen = 1'b0; wb_dst = '0;
    endtask

    task automatic do_reset(input logic byp);
        rst_n = 1'b0;
        bypass_en = byp;
        idle_inputs();
        repeat (2) @(posedge clk);
        #2;
        chk("R8 reset stall", int'(stall), 0);
        chk("R8 reset fwd", int'(src_from_wb), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk("R8 after reset bubble", int'(bubble), 0);
    endtask

    task automatic apply_vec(input vec_t v, input int k);
        bypass_en = v.byp; dec_valid = v.dv;
        dec_src_idx = {v.r2, v.r1}; dec_src_use = {v.u2, v.u1};
        ex_valid = v.xv; ex_wen = v.xw; ex_dst = v.xd;
        wb_valid = v.wv; wb_wen = v.ww; wb_dst = v.wd;
        #2;
        chk($sformatf("vector %0d (R1-R6 table) stall", k), int'(stall), int'(v.es));
        chk($sformatf("vector %0d (R1-R6 table) bubble", k), int'(bubble), int'(v.es));
        chk($sformatf("vector %0d (R1-R6 table) fwd", k), int'(src_from_wb), int'(v.ef));
        @(posedge clk); #2;
        idle_inputs();
        @(posedge clk); #2;
    endtask

    // Consumer reading r3 right behind a producer of r3
    task automatic back_to_back(input logic byp);
        do_reset(byp);
        dec_valid = 1'b1; dec_src_idx = {5'd1, 5'd3}; dec_src_use = 2'b11;
        ex_valid = 1'b1; ex_wen = 1'b1; ex_dst = 5'd3;
        #1;
        chk("R7 first stall", int'(stall), 1);
        @(posedge clk); #2;
        ex_valid = 1'b0; ex_wen = 1'b0; ex_dst = '0;
        wb_valid = 1'b1; wb_wen = 1'b1; wb_dst = 5'd3;
        #1;
        chk("R7 second cycle stall", int'(stall), byp ? 0 : 1);
        chk("R7 second cycle fwd", int'(src_from_wb), byp ? 1 : 0);
        @(posedge clk); #2;
        if (!byp) begin
            wb_valid = 1'b0; wb_wen = 1'b0; wb_dst = '0;
            #1;
            chk("R7 released after two", int'(stall), 0);
        end
        idle_inputs();
        @(posedge clk); #2;
    endtask

    task automatic run_prog(input logic byp, input logic [31:0] seed);
        logic [31:0] lcg;
        int pc, cyc, d_i, x_i, w_i;
        logic d_v, x_v, w_v, st;
        logic [1:0] fw;
        logic [31:0] x_a, x_b, w_res, n_res;
        lcg = seed;
        for (int i = 0; i < NI; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            p_op[i] = int'((lcg >> 16) % 32'd4);
            p_rd[i] = int'((lcg >> 8) % 32'd8);
            p_r2[i] = int'((lcg >> 20) % 32'd8);
            if (i > 0 && lcg[27]) p_r1[i] = p_rd[i-1];
            else p_r1[i] = int'((lcg >> 24) % 32'd8);
        end
        for (int k = 0; k < 8; k++) begin
            rf[k] = (k == 0) ? 32'd0 : 32'(k * 37 + 5);
            ref_rf[k] = rf[k];
        end
        // Sequential reference
        for (int i = 0; i < NI; i++) begin
            ref_res[i] = alu(p_op[i], ref_rf[p_r1[i]], ref_rf[p_r2[i]]);
            if (p_op[i] != 3 && p_rd[i] != 0) ref_rf[p_rd[i]] = ref_res[i];
        end
        // Expected execute-entry schedule: gap 3 without bypass, 2 with it
        t_s[0] = 0;
        for (int i = 1; i < NI; i++) begin
            int t;
            t = t_s[i-1] + 1;
            for (int s = 0; s < 2; s++) begin
                int src;
                src = (s == 0) ? p_r1[i] : p_r2[i];
                if (src != 0) begin
                    for (int j = i - 1; j >= 0; j--) begin
                        if (p_op[j] != 3 && p_rd[j] == src) begin
                            if (t_s[j] + (byp ? 2 : 3) > t) t = t_s[j] + (byp ? 2 : 3);
                            break;
                        end
                    end
                end
            end
            t_s[i] = t;
        end
        do_reset(byp);
        pc = 0; cyc = 0; d_i = 0; x_i = 0; w_i = 0;
        d_v = 1'b0; x_v = 1'b0; w_v = 1'b0;
        x_a = '0; x_b = '0; w_res = '0;
        while (!(pc >= NI && !d_v && !x_v && !w_v) && cyc < 4000) begin
            dec_valid = d_v;
            dec_src_idx = {AW'(p_r2[d_i]), AW'(p_r1[d_i])};
            dec_src_use = 2'b11;
            ex_valid = x_v; ex_wen = (p_op[x_i] != 3); ex_dst = AW'(p_rd[x_i]);
            wb_valid = w_v; wb_wen = (p_op[w_i] != 3); wb_dst = AW'(p_rd[w_i]);
            #1;
            st = stall; fw = src_from_wb;
            if (w_v) chk($sformatf("R9 result of instr %0d", w_i), int'(w_res), int'(ref_res[w_i]));
            n_res = alu(p_op[x_i], x_a, x_b);
            if (w_v && p_op[w_i] != 3 && p_rd[w_i] != 0) begin
                if (!st && d_v) begin
                    x_a = fw[0] ? w_res : rf[p_r1[d_i]];
                    x_b = fw[1] ? w_res : rf[p_r2[d_i]];
                end
                rf[p_rd[w_i]] = w_res;
            end else if (!st && d_v) begin
                x_a = fw[0] ? w_res : rf[p_r1[d_i]];
                x_b = fw[1] ? w_res : rf[p_r2[d_i]];
            end
            w_v = x_v; w_i = x_i; w_res = n_res;
            if (st) begin
                x_v = 1'b0;
            end else begin
                x_v = d_v; x_i = d_i;
                if (d_v) xc[d_i] = cyc + 1;
                if (pc < NI) begin d_v = 1'b1; d_i = pc; pc++; end
                else d_v = 1'b0;
            end
            cyc++;
            @(posedge clk); #2;
        end
        idle_inputs();
        chk("R9 drained", int'(cyc < 4000), 1);
        chk("R9 cycle span", xc[NI-1] - xc[0], t_s[NI-1] - t_s[0]);
        for (int k = 1; k < 8; k++)
            chk($sformatf("R9 final r%0d", k), int'(rf[k]), int'(ref_rf[k]));
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", WD);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        for (int k = 0; k < 13; k++) apply_vec(VEC[k], k);
        back_to_back(1'b0);
        back_to_back(1'b1);
        run_prog(1'b0, 32'h1234_5678);
        run_prog(1'b1, 32'h1234_5678);
        run_prog(1'b0, 32'h0bad_cafe);
        run_prog(1'b1, 32'h0bad_cafe);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule